// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page number by walking a two-level page table in memory. A client hands it a virtual address together with the page frame of the root table. The walker then reads one table entry per level over a single memory read port and returns either the 20-bit physical page number or a fault that names the level where the walk stopped.

Each table fills exactly one 4 KB page and holds 1024 four-byte entries. The top ten bits of the virtual address pick an entry in the root table. That entry gives the frame of a second-level table, and the next ten bits pick the entry there. The low twelve bits are the page offset, which the walker does not use. In every entry, bit 0 is the valid flag and bits 31:12 carry a frame number. If an entry has its valid flag clear, no table exists below it, so the walk ends at once.

Only one walk runs at a time and only one memory read is outstanding. The client may start a new walk only while the walker reports that it is ready.

Top module: `page_walker`

## Requirements
- R1: After reset, `reqReady` is 1 and `memReqValid` and `rspValid` are both 0.
- R2: The walker takes a request only when `reqValid` and `reqReady` are both 1, and `reqReady` is 1 only while the walker is idle. A request raised during a walk has no effect: the walk's read addresses and its response do not change, and no extra walk starts.
- R3: The first read is at byte address `rootBase*4096 + va[31:22]*4`.
- R4: When the first entry has bit 0 set, the second read is at byte address `entry1[31:12]*4096 + va[21:12]*4`.
- R5: When both entries have bit 0 set, the response gives `rspFault`=0, `rspLevel`=0 and `rspPpn`=`entry2[31:12]`.
- R6: When the first entry has bit 0 clear, the walker makes no second read. It responds with `rspFault`=1, `rspLevel`=1 and `rspPpn`=0.
- R7: When the second entry has bit 0 clear, the walker responds with `rspFault`=1, `rspLevel`=2 and `rspPpn`=0.
- R8: A read stays posted until it completes. `memReqValid` stays high and `memReqAddr` holds steady until a cycle in which `memRspValid` is 1, and that cycle completes the read.
- R9: `rspValid` is a one-cycle pulse. It rises in the cycle after the completing read, which is the second read on success or the read that returned the invalid entry on a fault. The walker is ready again in the cycle after the pulse.
- R10: The walk uses the address captured when the request was taken. Later changes on `reqVa` or `rootBase` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request |
| reqReady | output | 1 | Walker idle; request is taken this cycle |
| reqVa | input | 32 | Virtual address to translate |
| rootBase | input | 20 | Page frame of the root table |
| memReqValid | output | 1 | Entry read request, held until completion |
| memReqAddr | output | 32 | Byte address of the entry |
| memRspValid | input | 1 | Entry data valid; completes the read |
| memRspData | input | 32 | Entry contents |
| rspValid | output | 1 | Walk result pulse |
| rspFault | output | 1 | Walk ended on an invalid entry |
| rspLevel | output | 2 | Faulting level (1 or 2); 0 on success |
| rspPpn | output | 20 | Physical page number; 0 on fault |

## Verification
The first read request shows up in the cycle after the request is taken. Each later read request, or the result pulse, shows up in the cycle after the read that came before it completes. The result pulse lasts exactly one cycle and is followed by a ready cycle. The bench plays the memory itself from a task. It drives every response at the falling edge and samples the walker's outputs at the falling edge that follows each rising edge, so every check falls in the exact cycle where a value is due. Memory latency varies from zero to several wait cycles, which exercises the hold rule. During each walk the bench keeps a competing request with a different address on the inputs, and it confirms from the read addresses and the result that this request changed nothing.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_READ_L2,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic captureReq;   // latch VA and root frame, clear result
    logic loadNext;     // entry frame becomes next table base
    logic loadPpn;      // entry frame becomes the result
    logic levelSel;     // 0: first-level index, 1: second-level index
  } walkStrobes_t;
endpackage

// File: rtl/page_walker_ctrl.sv
module page_walker_ctrl
  import page_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  logic         entryValid,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         rspValid,
  output logic         rspFault,
  output logic [1:0]   rspLevel,
  output walkStrobes_t strobes
);
  walkState_t state, stateNext;
  logic [1:0] faultLvl, faultLvlNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      faultLvl <= 2'd0;
    end else begin
      state    <= stateNext;
      faultLvl <= faultLvlNext;
    end
  end

  always_comb begin
    stateNext    = state;
    faultLvlNext = faultLvl;
    strobes      = '0;
    reqReady     = 1'b0;
    memReqValid  = 1'b0;
    rspValid     = 1'b0;
    rspFault     = 1'b0;
    rspLevel     = 2'd0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.captureReq = 1'b1;
          faultLvlNext       = 2'd0;
          stateNext          = ST_READ_L1;
        end
      end
      ST_READ_L1: begin
        memReqValid = 1'b1;
        if (memRspValid) begin
          if (entryValid) begin
            strobes.loadNext = 1'b1;
            stateNext        = ST_READ_L2;
          end else begin
            faultLvlNext = 2'd1;
            stateNext    = ST_FAULT;
          end
        end
      end
      ST_READ_L2: begin
        memReqValid      = 1'b1;
        strobes.levelSel = 1'b1;
        if (memRspValid) begin
          if (entryValid) begin
            strobes.loadPpn = 1'b1;
            stateNext       = ST_DONE;
          end else begin
            faultLvlNext = 2'd2;
            stateNext    = ST_FAULT;
          end
        end
      end
      ST_DONE: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_FAULT: begin
        rspValid  = 1'b1;
        rspFault  = 1'b1;
        rspLevel  = faultLvl;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/page_walker_dp.sv
module page_walker_dp
  import page_walker_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LEVELS    = 2,
  parameter int PTE_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  walkStrobes_t                  strobes,
  input  logic [VA_W-1:0]               reqVa,
  input  logic [VA_W-PAGE_BITS-1:0]     rootBase,
  input  logic [VA_W-1:0]               memRspData,
  output logic                          entryValid,
  output logic [VA_W-1:0]               memReqAddr,
  output logic [VA_W-PAGE_BITS-1:0]     rspPpn
);
  localparam int PN_W      = VA_W - PAGE_BITS;
  localparam int IDX_W     = PN_W / LEVELS;
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);

  logic [PN_W-1:0]  vpnReg;
  logic [PN_W-1:0]  baseReg;
  logic [PN_W-1:0]  ppnReg;
  logic [IDX_W-1:0] idxField [LEVELS];
  logic [IDX_W-1:0] idxSel;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
    assign idxField[lv] = vpnReg[PN_W-1-lv*IDX_W -: IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnReg  <= '0;
      baseReg <= '0;
      ppnReg  <= '0;
    end else begin
      if (strobes.captureReq) begin
        vpnReg  <= reqVa[VA_W-1:PAGE_BITS];
        baseReg <= rootBase;
        ppnReg  <= '0;
      end
      if (strobes.loadNext) baseReg <= memRspData[VA_W-1:PAGE_BITS];
      if (strobes.loadPpn)  ppnReg  <= memRspData[VA_W-1:PAGE_BITS];
    end
  end

  assign idxSel     = strobes.levelSel ? idxField[1] : idxField[0];
  assign memReqAddr = {baseReg, {PAGE_BITS{1'b0}}} + (VA_W'(idxSel) << PTE_SHIFT);
  assign entryValid = memRspData[0];
  assign rspPpn     = ppnReg;
endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LEVELS    = 2,
  parameter int PTE_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [VA_W-1:0]           reqVa,
  input  logic [VA_W-PAGE_BITS-1:0] rootBase,
  output logic                      memReqValid,
  output logic [VA_W-1:0]           memReqAddr,
  input  logic                      memRspValid,
  input  logic [VA_W-1:0]           memRspData,
  output logic                      rspValid,
  output logic                      rspFault,
  output logic [1:0]                rspLevel,
  output logic [VA_W-PAGE_BITS-1:0] rspPpn
);
  walkStrobes_t strobes;
  logic         entryValid;

  page_walker_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .entryValid(entryValid), .reqReady(reqReady), .memReqValid(memReqValid),
    .rspValid(rspValid), .rspFault(rspFault), .rspLevel(rspLevel),
    .strobes(strobes)
  );

  page_walker_dp #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .LEVELS(LEVELS), .PTE_BYTES(PTE_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqVa(reqVa),
    .rootBase(rootBase), .memRspData(memRspData), .entryValid(entryValid),
    .memReqAddr(memReqAddr), .rspPpn(rspPpn)
  );
endmodule

// File: rtl/page_walker_checker.sv
module page_walker_checker #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqReady,
  input logic                      memReqValid,
  input logic [VA_W-1:0]           memReqAddr,
  input logic                      memRspValid,
  input logic                      rspValid,
  input logic                      rspFault,
  input logic [1:0]                rspLevel,
  input logic [VA_W-PAGE_BITS-1:0] rspPpn
);
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid && $stable(memReqAddr)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rspValid) |-> !reqReady); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && reqReady); // R9
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(memReqValid && memRspValid)); // R9
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> (rspLevel == 2'd1 || rspLevel == 2'd2) && rspPpn == '0); // R6
  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memReqValid); // R6
  AST_SUCCESS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspLevel == 2'd0); // R5
endmodule

bind page_walker page_walker_checker #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .memReqValid(memReqValid),
  .memReqAddr(memReqAddr), .memRspValid(memRspValid), .rspValid(rspValid),
  .rspFault(rspFault), .rspLevel(rspLevel), .rspPpn(rspPpn)
);

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic [19:0] rootBase = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic        rspFault;
  logic [1:0]  rspLevel;
  logic [19:0] rspPpn;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  page_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .rootBase(rootBase), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspFault(rspFault), .rspLevel(rspLevel), .rspPpn(rspPpn)
  );

  // Vectors: VA, root frame, first entry, second entry, wait cycles per read
  localparam int NV = 7;
  localparam logic [31:0] V_VA   [NV] = '{32'h0040_3123, 32'hFFFF_FFFF, 32'h0000_0000,
                                          32'h1234_5678, 32'hABCD_E000, 32'h8000_1FFF, 32'h7FC0_0ABC};
  localparam logic [19:0] V_ROOT [NV] = '{20'h00010, 20'hFFFFE, 20'h00000,
                                          20'h0A0A0, 20'h12345, 20'h55555, 20'h00001};
  localparam logic [31:0] V_E1   [NV] = '{32'h0002_0001, 32'h0003_3001, 32'h0000_1003,
                                          32'h0004_4000, 32'h0007_7001, 32'hFFFF_F001, 32'h0000_0000};
  localparam logic [31:0] V_E2   [NV] = '{32'h0ABC_D001, 32'hFFFF_F001, 32'h0000_0001,
                                          32'h0000_0000, 32'h0999_9000, 32'h1357_9FFF, 32'h0000_0000};
  localparam int V_WAIT [NV] = '{0, 1, 3, 0, 2, 5, 4};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Serve one read: hold for waitCycles, then return data; caller samples after next posedge
  task automatic serveRead(input string req, input logic [31:0] expAddr,
                           input logic [31:0] data, input int waitCycles, input bit lastRead);
    check({req, " read posted"}, 32'(memReqValid), 32'd1);
    check({req, " read addr"}, memReqAddr, expAddr);
    for (int w = 0; w < waitCycles; w++) begin
      @(posedge clk); @(negedge clk);
      check("R8 read held", 32'(memReqValid), 32'd1);
      check("R8 addr stable", memReqAddr, expAddr);
      check("R2 busy not ready", 32'(reqReady), 32'd0);
    end
    memRspValid = 1'b1;
    memRspData  = data;
    if (lastRead) reqValid = 1'b0;
    @(posedge clk); @(negedge clk);
    memRspValid = 1'b0;
    memRspData  = 32'hDEAD_BEE0;
  endtask

  task automatic runWalk(input logic [31:0] va, input logic [19:0] root,
                         input logic [31:0] e1, input logic [31:0] e2, input int waitCycles);
    logic [31:0] a1, a2;
    a1 = {root, 12'h000} + {20'h0, va[31:22], 2'b00};
    a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    check("R2 ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1;
    reqVa    = va;
    rootBase = root;
    @(posedge clk); @(negedge clk);
    // competing request with different inputs stays up during the walk (R2, R10)
    reqVa    = ~va;
    rootBase = ~root;
    serveRead("R3", a1, e1, waitCycles, !e1[0]);
    if (!e1[0]) begin
      check("R6 rsp valid", 32'(rspValid), 32'd1);
      check("R6 fault", 32'(rspFault), 32'd1);
      check("R6 level", 32'(rspLevel), 32'd1);
      check("R6 ppn zero", 32'(rspPpn), 32'd0);
      check("R6 no second read", 32'(memReqValid), 32'd0);
    end else begin
      serveRead("R4", a2, e2, waitCycles, 1'b1);
      check("R9 rsp valid", 32'(rspValid), 32'd1);
      if (e2[0]) begin
        check("R5 fault clear", 32'(rspFault), 32'd0);
        check("R5 level", 32'(rspLevel), 32'd0);
        check("R5 ppn", 32'(rspPpn), {12'h0, e2[31:12]});
      end else begin
        check("R7 fault", 32'(rspFault), 32'd1);
        check("R7 level", 32'(rspLevel), 32'd2);
        check("R7 ppn zero", 32'(rspPpn), 32'd0);
      end
    end
    @(posedge clk); @(negedge clk);
    check("R9 pulse ends", 32'(rspValid), 32'd0);
    check("R9 ready again", 32'(reqReady), 32'd1);
    check("R2 no extra walk", 32'(memReqValid), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready", 32'(reqReady), 32'd1);
    check("R1 no read", 32'(memReqValid), 32'd0);
    check("R1 no rsp", 32'(rspValid), 32'd0);

    for (int i = 0; i < NV; i++) runWalk(V_VA[i], V_ROOT[i], V_E1[i], V_E2[i], V_WAIT[i]);

    // idle with no request: nothing happens
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 idle quiet", 32'(memReqValid), 32'd0);

    // reset in the middle of a walk returns to the reset state
    reqValid = 1'b1; reqVa = 32'h0123_4567; rootBase = 20'h00100;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check("R3 read posted", 32'(memReqValid), 32'd1);
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1;
    check("R1 ready after reset", 32'(reqReady), 32'd1);
    check("R1 read dropped", 32'(memReqValid), 32'd0);
    check("R1 rsp low", 32'(rspValid), 32'd0);

    // back-to-back walk after reset still resolves
    runWalk(32'h0040_3123, 20'h00010, 32'h0002_0001, 32'h0ABC_D001, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule